// File: doc/BRIEF.md
# Element batch independence checker

This block decides whether two vector elements may skip inter-element hazard tracking. Software programs a parallelism hint. Elements whose step indices give the same floor quotient when divided by that hint belong to one independence batch. The hint is any 7-bit value and need not be a power of two. Hardware may also supply a smaller effective hint of its own. Two elements are then independent only when they share a batch under both divisors, so grouping never crosses a programmed boundary.

One request carries two source step indices and two destination step indices, and the two pairs are judged separately. A zero hint means no hint. A disable input, raised for atomic, uncached, reserve/conditional or pointer-chasing accesses, has the same effect as a zero hint. Steps are the raw indices, taken before any remapping or predicate mask. A restoring divider works out the quotients one bit per cycle behind a valid/ready handshake. The result is registered and announced with a one-cycle done pulse.

Top module: `bic_batch_check`

## Requirements
- R1: `req_ready` is high when idle and falls the cycle after a request is taken (`req_valid && req_ready` at a rising edge). `done` is a single-cycle pulse that is high exactly W+1 = 8 clock edges after the accepting edge, and `req_ready` rises again in that same cycle.
- R2: For a nonzero hint, each batch output equals floor(step / hint) for any hint from 1 to 127, including non-powers of two.
- R3: `src_same` is 1 exactly when both source steps have equal programmed batch numbers and equal effective batch numbers.
- R4: `dst_same` is evaluated from the destination steps alone, so it may differ from `src_same`.
- R5: With hint 0, each batch output equals its step index, and a same flag is 1 only for identical steps.
- R6: With `indep_off` = 1, results equal those for hint 0, whatever the hint.
- R7: An effective hint that is nonzero and smaller than the hint also splits batches: steps in one programmed batch but in different effective batches are reported as not the same.
- R8: An effective hint of 0, or one not smaller than the hint, has no effect on any output.
- R9: A hint larger than both steps of a pair puts the pair in batch 0 with its same flag set.
- R10: Identical step indices always give a same flag of 1, for every hint value and for `indep_off`.
- R11: After reset all outputs are 0 and `req_ready` is 1. Between done pulses, the flags and batch outputs hold their last values.
- R12: Changes on the data inputs and on `req_valid` while a request is in progress have no effect on the result of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, able to take a request |
| hint | input | W | Programmed parallelism hint, 0 = none |
| eff_hint | input | W | Effective hint chosen by hardware, 0 = same as hint |
| indep_off | input | 1 | Force behaviour of hint 0 |
| src_step_a | input | W | First source step index |
| src_step_b | input | W | Second source step index |
| dst_step_a | input | W | First destination step index |
| dst_step_b | input | W | Second destination step index |
| done | output | 1 | One-cycle result pulse |
| src_same | output | 1 | Source pair independent |
| dst_same | output | 1 | Destination pair independent |
| src_batch_a | output | W | Programmed batch of src_step_a |
| src_batch_b | output | W | Programmed batch of src_step_b |
| dst_batch_a | output | W | Programmed batch of dst_step_a |
| dst_batch_b | output | W | Programmed batch of dst_step_b |

## Verification
The assertions check the following on every cycle:
- the handshake timing and the single-cycle done pulse;
- the fixed latency;
- that a set flag implies equal programmed batches;
- that identical steps are flagged as the same batch;
- that with a zero or disabled hint the batch outputs equal the steps;
- that a batch never exceeds its step;
- that outputs hold between pulses.

The exact quotients for non-power-of-two divisors, the splitting by the effective hint, and its neglect when that hint is zero or too large can only be shown by the bench's scenarios. The same holds for source and destination pairs that disagree and for inputs that change while a request is in progress. The bench compares these against an integer-division model.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int unsigned BIC_PAIRS  = 2;
  localparam int unsigned BIC_STEPS  = 2 * BIC_PAIRS;
  localparam int unsigned BIC_LANES  = 2 * BIC_STEPS;

  typedef enum logic [1:0] {
    BIC_IDLE = 2'd0,
    BIC_RUN  = 2'd1,
    BIC_FIN  = 2'd2
  } bic_state_e;
endpackage

// File: rtl/bic_seq.sv
module bic_seq #(
  parameter int unsigned W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  output logic req_ready,
  output logic start,
  output logic step_en,
  output logic finish
);
  import bic_pkg::*;

  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  bic_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign req_ready = (state_q == BIC_IDLE);
  assign start     = req_valid && req_ready;
  assign step_en   = (state_q == BIC_RUN);
  assign finish    = (state_q == BIC_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BIC_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        BIC_IDLE: if (start) begin
          state_q <= BIC_RUN;
          cnt_q   <= '0;
        end
        BIC_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= BIC_FIN;
        end
        default: state_q <= BIC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bic_div_lane.sv
module bic_div_lane #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         step_en,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W:0]   shifted, trial;
  logic         fits;

  assign shifted  = {rem_q, quo_q[W-1]};
  assign fits     = shifted >= {1'b0, dvs_q};
  assign trial    = shifted - {1'b0, dvs_q};
  assign quotient = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (start) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step_en) begin
      if (fits) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/bic_batch_check.sv
module bic_batch_check #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] hint,
  input  logic [W-1:0] eff_hint,
  input  logic         indep_off,
  input  logic [W-1:0] src_step_a,
  input  logic [W-1:0] src_step_b,
  input  logic [W-1:0] dst_step_a,
  input  logic [W-1:0] dst_step_b,
  output logic         done,
  output logic         src_same,
  output logic         dst_same,
  output logic [W-1:0] src_batch_a,
  output logic [W-1:0] src_batch_b,
  output logic [W-1:0] dst_batch_a,
  output logic [W-1:0] dst_batch_b
);
  import bic_pkg::*;

  logic start, step_en, finish;
  logic [W-1:0] div_prog, div_eff;
  logic [W-1:0] steps [BIC_STEPS];
  logic [W-1:0] quo   [BIC_LANES];

  bic_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .start(start), .step_en(step_en), .finish(finish)
  );

  // A missing or disabled hint divides by one: every step is its own batch.
  always_comb begin
    div_prog = (hint == '0 || indep_off) ? W'(1) : hint;
    div_eff  = (eff_hint == '0 || eff_hint >= div_prog) ? div_prog : eff_hint;
  end

  assign steps[0] = src_step_a;
  assign steps[1] = src_step_b;
  assign steps[2] = dst_step_a;
  assign steps[3] = dst_step_b;

  // Lanes 0..3 use the programmed divisor, lanes 4..7 the effective one.
  for (genvar g = 0; g < BIC_LANES; g++) begin : g_lane
    localparam int unsigned SI = g % BIC_STEPS;
    bic_div_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst), .start(start), .step_en(step_en),
      .dividend(steps[SI]),
      .divisor((g < BIC_STEPS) ? div_prog : div_eff),
      .quotient(quo[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      src_same    <= 1'b0;
      dst_same    <= 1'b0;
      src_batch_a <= '0;
      src_batch_b <= '0;
      dst_batch_a <= '0;
      dst_batch_b <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        src_same    <= (quo[0] == quo[1]) && (quo[4] == quo[5]);
        dst_same    <= (quo[2] == quo[3]) && (quo[6] == quo[7]);
        src_batch_a <= quo[0];
        src_batch_b <= quo[1];
        dst_batch_a <= quo[2];
        dst_batch_b <= quo[3];
      end
    end
  end
endmodule

// File: rtl/bic_batch_check_sva.sv
module bic_batch_check_sva #(
  parameter int unsigned W = 7
) (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic         req_ready,
  input logic [W-1:0] hint,
  input logic         indep_off,
  input logic [W-1:0] src_step_a,
  input logic [W-1:0] src_step_b,
  input logic [W-1:0] dst_step_a,
  input logic [W-1:0] dst_step_b,
  input logic         done,
  input logic         src_same,
  input logic         dst_same,
  input logic [W-1:0] src_batch_a,
  input logic [W-1:0] src_batch_b,
  input logic [W-1:0] dst_batch_a,
  input logic [W-1:0] dst_batch_b
);
  localparam int unsigned LAT = W + 1;

  logic         seen;
  logic [7:0]   since;
  logic [W-1:0] c_sa, c_sb, c_da, c_db;
  logic         c_nohint;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0; since <= '0; c_sa <= '0; c_sb <= '0;
      c_da <= '0; c_db <= '0; c_nohint <= 1'b0;
    end else if (req_valid && req_ready) begin
      seen <= 1'b1; since <= '0;
      c_sa <= src_step_a; c_sb <= src_step_b;
      c_da <= dst_step_a; c_db <= dst_step_b;
      c_nohint <= (hint == '0) || indep_off;
    end else if (since != 8'hff) begin
      since <= since + 1'b1;
    end
  end

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_latency_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> (seen && since == 8'(LAT) && req_ready));
  p_batch_le_step_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (src_batch_a <= c_sa && dst_batch_b <= c_db));
  p_same_src_batch_r3: assert property (@(posedge clk) disable iff (rst)
    (done && src_same) |-> (src_batch_a == src_batch_b));
  p_same_dst_batch_r4: assert property (@(posedge clk) disable iff (rst)
    (done && dst_same) |-> (dst_batch_a == dst_batch_b));
  p_no_hint_r5: assert property (@(posedge clk) disable iff (rst)
    (done && c_nohint) |-> (src_batch_a == c_sa && dst_batch_a == c_da &&
                            src_same == (c_sa == c_sb) && dst_same == (c_da == c_db)));
  p_identical_r10: assert property (@(posedge clk) disable iff (rst)
    (done && c_sa == c_sb) |-> src_same);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(src_same) && $stable(dst_same) &&
               $stable(src_batch_a) && $stable(dst_batch_b)));
endmodule

bind bic_batch_check bic_batch_check_sva #(.W(W)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .hint(hint), .indep_off(indep_off),
  .src_step_a(src_step_a), .src_step_b(src_step_b),
  .dst_step_a(dst_step_a), .dst_step_b(dst_step_b),
  .done(done), .src_same(src_same), .dst_same(dst_same),
  .src_batch_a(src_batch_a), .src_batch_b(src_batch_b),
  .dst_batch_a(dst_batch_a), .dst_batch_b(dst_batch_b)
);

// File: tb/test_bic_batch_check.sv
module test_bic_batch_check;
  localparam int W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [W-1:0] hint = '0, eff_hint = '0;
  logic indep_off = 1'b0;
  logic [W-1:0] src_step_a = '0, src_step_b = '0, dst_step_a = '0, dst_step_b = '0;
  logic done, src_same, dst_same;
  logic [W-1:0] src_batch_a, src_batch_b, dst_batch_a, dst_batch_b;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bic_batch_check #(.W(W)) i_bic_batch_check (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_batch(int s, int h, bit off);
    return (h == 0 || off) ? s : s / h;
  endfunction

  function automatic int ref_same(int a, int b, int h, int e, bit off);
    int dp, de;
    if (a == b) return 1;
    if (h == 0 || off) return 0;
    dp = h;
    de = (e == 0 || e >= dp) ? dp : e;
    return (a / dp == b / dp) && (a / de == b / de);
  endfunction

  task automatic run_case(input string tag, input int h, input int e, input bit off,
                          input int sa, input int sb, input int da, input int db);
    int exp_ss, exp_ds;
    @(negedge clk);
    hint = W'(h); eff_hint = W'(e); indep_off = off;
    src_step_a = W'(sa); src_step_b = W'(sb); dst_step_a = W'(da); dst_step_b = W'(db);
    req_valid = 1'b1;
    exp_ss = ref_same(sa, sb, h, e, off);
    exp_ds = ref_same(da, db, h, e, off);
    @(posedge clk);
    for (int n = 1; n <= W + 2; n++) begin
      @(negedge clk);
      chk("R1 ready", int'(req_ready), (n == W + 2) ? 1 : 0);
      chk("R1 done", int'(done), (n == W + 2) ? 1 : 0);
      // R12: scramble inputs while busy
      hint = W'($urandom); eff_hint = W'($urandom); indep_off = 1'($urandom);
      src_step_a = W'($urandom); src_step_b = W'($urandom);
      dst_step_a = W'($urandom); dst_step_b = W'($urandom);
      req_valid = (n == W + 2) ? 1'b0 : 1'($urandom);
    end
    chk({tag, " src_same"}, int'(src_same), exp_ss);
    chk({tag, " dst_same"}, int'(dst_same), exp_ds);
    chk("R2 src_batch_a", int'(src_batch_a), ref_batch(sa, h, off));
    chk("R2 src_batch_b", int'(src_batch_b), ref_batch(sb, h, off));
    chk("R2 dst_batch_a", int'(dst_batch_a), ref_batch(da, h, off));
    chk("R2 dst_batch_b", int'(dst_batch_b), ref_batch(db, h, off));
    @(negedge clk);
    chk("R1 pulse", int'(done), 0);
    chk("R11 hold", int'(src_same), exp_ss);
    chk("R11 hold batch", int'(dst_batch_b), ref_batch(db, h, off));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R11 reset ready", int'(req_ready), 1);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset flags", int'({src_same, dst_same}), 0);
    chk("R11 reset batch", int'(src_batch_a), 0);

    run_case("R3", 3, 0, 0, 4, 5, 5, 6);
    run_case("R2", 7, 0, 0, 13, 14, 20, 21);
    run_case("R4", 5, 0, 0, 10, 14, 9, 10);
    run_case("R5", 0, 0, 0, 3, 4, 9, 9);
    run_case("R6", 9, 0, 1, 1, 2, 6, 6);
    run_case("R7", 6, 4, 0, 4, 5, 3, 4);
    run_case("R8", 6, 9, 0, 3, 4, 6, 11);
    run_case("R8", 6, 6, 0, 0, 5, 7, 12);
    run_case("R9", 100, 0, 0, 0, 99, 40, 2);
    run_case("R9", 127, 0, 0, 126, 127, 0, 126);
    run_case("R10", 0, 0, 1, 77, 77, 127, 127);
    run_case("R10", 1, 0, 0, 8, 8, 8, 9);
    run_case("R2", 127, 126, 0, 127, 127, 1, 126);
    for (int k = 0; k < 40; k++)
      run_case("R3", int'($urandom_range(0, 127)), int'($urandom_range(0, 127)),
               1'($urandom_range(0, 7) == 0),
               int'($urandom_range(0, 127)), int'($urandom_range(0, 127)),
               int'($urandom_range(0, 127)), int'($urandom_range(0, 127)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule